// File: doc/BRIEF.md
# Programmable Counter Array Timer

This block is a shared time base with several independent compare/capture channels. One 16-bit counter is clocked from a selectable source and feeds five identical channels. Each channel is set to one function: latch the counter on an input edge, flag a counter match, toggle its output pin on a match, or drive an 8-bit pulse-width output.

Software reaches the block through a flat 6-bit register space using a write strobe and a combinational read port. Hardware sets the event flags and the overflow flag. Software clears them by writing zeros. A single interrupt request combines every enabled flag.

Register layout:

- `0x00` configures the block: bit 0 enables the overflow interrupt, bits 2:1 select the source, bit 7 enables stop-on-idle.
- `0x01` holds control and flags: bit 7 is the overflow flag, bit 6 is run, bits 4:0 are the channel event flags.
- `0x02` and `0x03` are the low and high bytes of the counter.
- `0x08+n` is the mode register of channel n.
- `0x10+n` and `0x18+n` are the low and high compare/capture bytes of channel n.

Channel mode bits:

| Bit | Meaning |
|---|---|
| 6 | compare enable |
| 5 | rising capture |
| 4 | falling capture |
| 3 | match |
| 2 | toggle |
| 1 | pwm |
| 0 | event interrupt enable |

Top module: `pca_timer`

## Requirements
- R1: After reset the counter, all flags, the run bit, all channel registers, `irq_o` and every `cex_o` bit are zero.
- R2: The counter increments by one per source tick only while run (0x01 bit 6) is 1. It also holds while stop-on-idle (0x00 bit 7) is 1 and `idle_i` is high.
- R3: Source select (0x00 bits 2:1) picks the tick: 00 is one tick per 12 clocks, 01 is one per 4 clocks, 10 is each cycle `t0_ovf_i` is high, 11 is each rising edge of `ext_clk_i` after a two-flop synchronizer.
- R4: A tick at 0xFFFF wraps the counter to 0x0000 and sets the overflow flag (0x01 bit 7).
- R5: A channel with rising (bit 5) and/or falling (bit 4) capture set copies the counter into its 16-bit register on the chosen edge of its synchronized `cex_i` bit and sets its event flag. An edge of the unselected polarity changes nothing.
- R6: With compare enable and match set and pwm clear, a tick that brings the counter equal to the channel register sets the channel event flag.
- R7: In that compare setup with toggle (bit 2) also set, the channel `cex_o` bit inverts on every match and holds otherwise.
- R8: With pwm (bit 1) and compare enable set, `cex_o` is 1 when the counter low byte is at or above the register low byte and 0 below it. A tick carrying the counter low byte from 0xFF to 0x00 copies the register high byte into its low byte.
- R9: Writing a channel low compare byte clears its compare enable bit. Writing its high compare byte sets that bit.
- R10: Writing 0x01 clears each flag whose bit is written 0 and leaves flags written 1 unchanged. A hardware set in the same cycle as a clear leaves the flag set.
- R11: `irq_o` is high exactly when the overflow flag is set with its enable (0x00 bit 0), or any channel event flag is set with that channel's mode bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| t0_ovf_i | input | 1 | Overflow pulse from an external timer |
| ext_clk_i | input | 1 | Asynchronous external count input |
| idle_i | input | 1 | Idle-mode indication |
| cex_i | input | 5 | Per-channel capture inputs |
| cex_o | output | 5 | Per-channel toggle/PWM outputs |
| ovf_flag_o | output | 1 | Counter overflow flag |
| ev_flag_o | output | 5 | Per-channel event flags |
| irq_o | output | 1 | Combined interrupt request |

## Verification
Two functions can meet on one clock edge: a software write to the flag register that clears a flag, and a hardware event that sets the same flag. The bench provokes this by driving the overflow-causing tick and a flag-clearing write in the same cycle, with the counter parked at 0xFFFF. It judges the result by reading back a set overflow flag. A second overlap is the PWM low-byte reload, which happens on the same tick that wraps the low byte. The bench checks that the output afterwards follows the new threshold.

// File: rtl/pca_pkg.sv
// Package: shared address map and mode-bit positions for the counter array.
// Assumes a 6-bit register address and byte-wide data.
package pca_pkg;
    localparam int AW = 6;
    localparam logic [AW-1:0] A_CFG     = 6'h00;
    localparam logic [AW-1:0] A_CTL     = 6'h01;
    localparam logic [AW-1:0] A_CNT_LO  = 6'h02;
    localparam logic [AW-1:0] A_CNT_HI  = 6'h03;
    localparam logic [AW-1:0] A_MODE    = 6'h08;
    localparam logic [AW-1:0] A_CMP_LO  = 6'h10;
    localparam logic [AW-1:0] A_CMP_HI  = 6'h18;

    // channel mode bit positions
    localparam int M_IE  = 0;
    localparam int M_PWM = 1;
    localparam int M_TOG = 2;
    localparam int M_MAT = 3;
    localparam int M_NEG = 4;
    localparam int M_POS = 5;
    localparam int M_CMP = 6;
    localparam int MODE_W = 7;

    typedef enum logic [1:0] {
        SRC_SLOW = 2'b00,
        SRC_FAST = 2'b01,
        SRC_T0   = 2'b10,
        SRC_EXT  = 2'b11
    } src_e;
endpackage

// File: rtl/pca_tbase.sv
// Module: shared time base. Prescales the clock, picks a tick source,
// gates it with run/idle, and keeps the 16-bit counter.
// Assumes t0_ovf_i is synchronous to clk; ext_clk_i may be asynchronous.
module pca_tbase
    import pca_pkg::*;
#(
    parameter int CW        = 16,
    parameter int DIV_SLOW  = 12,
    parameter int DIV_FAST  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          idle_stop,
    input  logic          idle_i,
    input  src_e          src,
    input  logic          t0_ovf_i,
    input  logic          ext_clk_i,
    input  logic          wr_lo,
    input  logic          wr_hi,
    input  logic [7:0]    wdata,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt,
    output logic          tick,
    output logic          wrap,
    output logic          lo_wrap
);
    localparam int SW = $clog2(DIV_SLOW);
    localparam int FW = $clog2(DIV_FAST);
    localparam int HB = CW - 8;

    logic [SW-1:0] pre_s;
    logic [FW-1:0] pre_f;
    logic [2:0]    ext_sy;
    logic          src_pulse;

    // free-running prescalers for the two divided sources
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pre_s <= '0;
            pre_f <= '0;
        end else begin
            pre_s <= (pre_s == SW'(DIV_SLOW-1)) ? '0 : pre_s + SW'(1);
            pre_f <= (pre_f == FW'(DIV_FAST-1)) ? '0 : pre_f + FW'(1);
        end
    end

    // two-flop synchronizer plus edge history for the external input
    always_ff @(posedge clk) begin
        if (!rst_n) ext_sy <= '0;
        else        ext_sy <= {ext_sy[1:0], ext_clk_i};
    end

    // source select and gating
    always_comb begin
        unique case (src)
            SRC_SLOW: src_pulse = (pre_s == SW'(DIV_SLOW-1));
            SRC_FAST: src_pulse = (pre_f == FW'(DIV_FAST-1));
            SRC_T0:   src_pulse = t0_ovf_i;
            default:  src_pulse = ext_sy[1] & ~ext_sy[2];
        endcase
        tick    = src_pulse & run & ~(idle_stop & idle_i);
        cnt_nxt = cnt + CW'(1);
        wrap    = tick & (cnt == {CW{1'b1}});
        lo_wrap = tick & (cnt[7:0] == 8'hFF);
    end

    // counter: byte writes take precedence over counting
    always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (wr_lo || wr_hi) begin
            if (wr_lo) cnt[7:0]    <= wdata;
            if (wr_hi) cnt[CW-1:8] <= wdata[HB-1:0];
        end else if (tick) cnt <= cnt_nxt;
    end
endmodule

// File: rtl/pca_unit.sv
// Module: one compare/capture channel. Holds its mode, 16-bit register,
// event flag and toggle state; produces its output pin.
// Assumes CW is twice the byte width and the counter arrives from pca_tbase.
module pca_unit
    import pca_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              lo_wrap,
    input  logic [CW-1:0]     cnt,
    input  logic [CW-1:0]     cnt_nxt,
    input  logic              cex_i,
    input  logic              wr_mode,
    input  logic              wr_lo,
    input  logic              wr_hi,
    input  logic              flag_clr,
    input  logic [7:0]        wdata,
    output logic [MODE_W-1:0] mode_o,
    output logic [CW-1:0]     cap_o,
    output logic              flag_o,
    output logic              cex_o
);
    localparam int HB = CW - 8;

    logic [2:0] in_sy;
    logic       tog_q;
    logic       cap_ev, hit, reload;

    // synchronizer and edge history for the capture input
    always_ff @(posedge clk) begin
        if (!rst_n) in_sy <= '0;
        else        in_sy <= {in_sy[1:0], cex_i};
    end

    // event decode
    always_comb begin
        cap_ev = (mode_o[M_POS] &  in_sy[1] & ~in_sy[2])
               | (mode_o[M_NEG] & ~in_sy[1] &  in_sy[2]);
        hit    = tick & mode_o[M_CMP] & mode_o[M_MAT] & ~mode_o[M_PWM]
               & (cnt_nxt == cap_o);
        reload = lo_wrap & mode_o[M_PWM] & mode_o[M_CMP];
    end

    // mode register with compare-enable side effects of register writes
    always_ff @(posedge clk) begin
        if (!rst_n)       mode_o <= '0;
        else if (wr_mode) mode_o <= wdata[MODE_W-1:0];
        else if (wr_lo)   mode_o[M_CMP] <= 1'b0;
        else if (wr_hi)   mode_o[M_CMP] <= 1'b1;
    end

    // compare/capture register: bus write, PWM reload, then capture
    always_ff @(posedge clk) begin
        if (!rst_n) cap_o <= '0;
        else begin
            if (wr_lo)       cap_o[7:0] <= wdata;
            else if (reload) cap_o[7:0] <= cap_o[CW-1:8];
            else if (cap_ev) cap_o[7:0] <= cnt[7:0];
            if (wr_hi)       cap_o[CW-1:8] <= wdata[HB-1:0];
            else if (cap_ev) cap_o[CW-1:8] <= cnt[CW-1:8];
        end
    end

    // event flag (set wins over clear) and toggle state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
            tog_q  <= 1'b0;
        end else begin
            flag_o <= cap_ev | hit | (flag_o & ~flag_clr);
            if (hit && mode_o[M_TOG]) tog_q <= ~tog_q;
        end
    end

    // output pin: PWM comparison or toggle state
    assign cex_o = mode_o[M_PWM] ? (mode_o[M_CMP] & (cnt[7:0] >= cap_o[7:0])) : tog_q;
endmodule

// File: rtl/pca_timer.sv
// Module: top of the counter array. Decodes the register space, holds the
// block configuration and overflow flag, and instantiates the channels.
// Assumes NUM_MOD <= 6 so channel flags fit below the run bit.
module pca_timer
    import pca_pkg::*;
#(
    parameter int NUM_MOD  = 5,
    parameter int CW       = 16,
    parameter int DIV_SLOW = 12,
    parameter int DIV_FAST = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [7:0]         wdata,
    output logic [7:0]         rdata,
    input  logic               t0_ovf_i,
    input  logic               ext_clk_i,
    input  logic               idle_i,
    input  logic [NUM_MOD-1:0] cex_i,
    output logic [NUM_MOD-1:0] cex_o,
    output logic               ovf_flag_o,
    output logic [NUM_MOD-1:0] ev_flag_o,
    output logic               irq_o
);
    logic              run_q, idle_stop_q, ovf_ie_q;
    src_e              src_q;
    logic [CW-1:0]     cnt, cnt_nxt;
    logic              tick, wrap, lo_wrap;
    logic              ctl_wr;
    logic [NUM_MOD-1:0] ev_ie, cmp_en_v;
    logic [MODE_W-1:0] mode_q [NUM_MOD];
    logic [CW-1:0]     cap_q  [NUM_MOD];

    assign ctl_wr = wr_en && (addr == A_CTL);

    // block configuration, run bit and overflow flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q <= 1'b0; idle_stop_q <= 1'b0; ovf_ie_q <= 1'b0;
            src_q <= SRC_SLOW; ovf_flag_o <= 1'b0;
        end else begin
            if (wr_en && addr == A_CFG) begin
                ovf_ie_q    <= wdata[0];
                src_q       <= src_e'(wdata[2:1]);
                idle_stop_q <= wdata[7];
            end
            if (ctl_wr) run_q <= wdata[6];
            ovf_flag_o <= wrap | (ovf_flag_o & ~(ctl_wr & ~wdata[7]));
        end
    end

    pca_tbase #(.CW(CW), .DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_tbase (
        .clk(clk), .rst_n(rst_n), .run(run_q), .idle_stop(idle_stop_q),
        .idle_i(idle_i), .src(src_q), .t0_ovf_i(t0_ovf_i), .ext_clk_i(ext_clk_i),
        .wr_lo(wr_en && addr == A_CNT_LO), .wr_hi(wr_en && addr == A_CNT_HI),
        .wdata(wdata), .cnt(cnt), .cnt_nxt(cnt_nxt), .tick(tick),
        .wrap(wrap), .lo_wrap(lo_wrap)
    );

    for (genvar i = 0; i < NUM_MOD; i++) begin : g_unit
        pca_unit #(.CW(CW)) u_unit (
            .clk(clk), .rst_n(rst_n), .tick(tick), .lo_wrap(lo_wrap),
            .cnt(cnt), .cnt_nxt(cnt_nxt), .cex_i(cex_i[i]),
            .wr_mode(wr_en && addr == AW'(A_MODE + i)),
            .wr_lo(wr_en && addr == AW'(A_CMP_LO + i)),
            .wr_hi(wr_en && addr == AW'(A_CMP_HI + i)),
            .flag_clr(ctl_wr & ~wdata[i]), .wdata(wdata),
            .mode_o(mode_q[i]), .cap_o(cap_q[i]),
            .flag_o(ev_flag_o[i]), .cex_o(cex_o[i])
        );
        assign ev_ie[i]    = mode_q[i][M_IE];
        assign cmp_en_v[i] = mode_q[i][M_CMP];
    end

    // combined interrupt request
    assign irq_o = (ovf_flag_o & ovf_ie_q) | (|(ev_flag_o & ev_ie));

    // read multiplexer
    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:    rdata = {idle_stop_q, 4'b0, src_q, ovf_ie_q};
            A_CTL:    begin
                          rdata[7] = ovf_flag_o;
                          rdata[6] = run_q;
                          rdata[NUM_MOD-1:0] = ev_flag_o;
                      end
            A_CNT_LO: rdata = cnt[7:0];
            A_CNT_HI: rdata = 8'(cnt[CW-1:8]);
            default:  begin
                for (int i = 0; i < NUM_MOD; i++) begin
                    if (addr == AW'(A_MODE + i))   rdata = 8'(mode_q[i]);
                    if (addr == AW'(A_CMP_LO + i)) rdata = cap_q[i][7:0];
                    if (addr == AW'(A_CMP_HI + i)) rdata = 8'(cap_q[i][CW-1:8]);
                end
            end
        endcase
    end
endmodule

// File: rtl/pca_timer_chk.sv
// Module: property checker for pca_timer, attached by bind below.
// Assumes the signal names of the top module.
module pca_timer_chk
    import pca_pkg::*;
#(
    parameter int NUM_MOD = 5,
    parameter int CW      = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               wr_en,
    input logic [AW-1:0]      addr,
    input logic [CW-1:0]      cnt,
    input logic               tick,
    input logic               ovf_flag,
    input logic [NUM_MOD-1:0] ev_flag,
    input logic [NUM_MOD-1:0] cmp_en_v,
    input logic               irq
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == A_CNT_LO || addr == A_CNT_HI);

    // R2
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(cnt));

    // R2
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr) |=> cnt == $past(cnt) + CW'(1));

    // R4
    ovf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && cnt == {CW{1'b1}}) |=> ovf_flag);

    // R10
    ovf_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ovf_flag) |-> $past(wr_en && addr == A_CTL));

    // R10
    ev_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(ev_flag) & ~ev_flag)) |-> $past(wr_en && addr == A_CTL));

    // R9
    lo_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CMP_LO) |=> !cmp_en_v[0]);

    // R11
    irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf_flag || (|ev_flag)));
endmodule

bind pca_timer pca_timer_chk #(.NUM_MOD(NUM_MOD), .CW(CW)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .cnt(cnt),
    .tick(tick), .ovf_flag(ovf_flag_o), .ev_flag(ev_flag_o),
    .cmp_en_v(cmp_en_v), .irq(irq_o)
);

// File: tb/pca_timer_tb.sv
module pca_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [5:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       t0_ovf_i = 1'b0, ext_clk_i = 1'b0, idle_i = 1'b0;
    logic [4:0] cex_i = '0;
    logic [4:0] cex_o;
    logic       ovf_flag_o, irq_o;
    logic [4:0] ev_flag_o;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pca_timer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .t0_ovf_i(t0_ovf_i), .ext_clk_i(ext_clk_i),
        .idle_i(idle_i), .cex_i(cex_i), .cex_o(cex_o),
        .ovf_flag_o(ovf_flag_o), .ev_flag_o(ev_flag_o), .irq_o(irq_o)
    );

    // PWM vectors: {threshold low byte, counter low byte, expected pin}
    localparam logic [16:0] PWM_VEC [6] = '{
        {8'h40, 8'h10, 1'b0}, {8'h40, 8'h3F, 1'b0}, {8'h40, 8'h40, 1'b1},
        {8'h40, 8'hC0, 1'b1}, {8'h00, 8'h00, 1'b1}, {8'hFF, 8'hFE, 1'b0}
    };

    task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [5:0] a, logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(logic [5:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic set_cnt(logic [15:0] v);
        wr(6'h02, v[7:0]); wr(6'h03, v[15:8]);
    endtask

    task automatic rd_cnt(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(6'h02, lo); rd(6'h03, hi); v = {hi, lo};
    endtask

    task automatic t0_pulse();
        @(negedge clk); t0_ovf_i = 1'b1;
        @(negedge clk); t0_ovf_i = 1'b0;
    endtask

    task automatic settle(); repeat (4) @(negedge clk); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] c;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(6'h01, r); chk("R1 ctl", 16'(r), 16'h00);
        rd_cnt(c);    chk("R1 cnt", c, 16'h0000);
        rd(6'h08, r); chk("R1 mode", 16'(r), 16'h00);
        chk("R1 pins", {10'b0, irq_o, cex_o}, 16'h0);

        // R3 divide-by-12 source over a 120-edge run window
        wr(6'h00, 8'h00); wr(6'h01, 8'h40);
        repeat (118) @(negedge clk);
        wr(6'h01, 8'h00); rd_cnt(c); chk("R3 div12", c, 16'd10);
        // R3 divide-by-4 source
        set_cnt(16'h0); wr(6'h00, 8'h02); wr(6'h01, 8'h40);
        repeat (118) @(negedge clk);
        wr(6'h01, 8'h00); rd_cnt(c); chk("R3 div4", c, 16'd30);
        // R3 timer-0 overflow source
        set_cnt(16'h0); wr(6'h00, 8'h04); wr(6'h01, 8'h40);
        repeat (3) t0_pulse();
        rd_cnt(c); chk("R3 t0", c, 16'd3);
        // R3 external rising edges
        wr(6'h00, 8'h06);
        for (int k = 0; k < 2; k++) begin
            @(negedge clk); ext_clk_i = 1'b1; repeat (3) @(negedge clk);
            ext_clk_i = 1'b0; repeat (3) @(negedge clk);
        end
        settle(); rd_cnt(c); chk("R3 ext", c, 16'd5);
        // R2 idle stop
        wr(6'h00, 8'h84); idle_i = 1'b1;
        repeat (2) t0_pulse();
        rd_cnt(c); chk("R2 idle hold", c, 16'd5);
        wr(6'h00, 8'h04); t0_pulse();
        rd_cnt(c); chk("R2 idle ignored", c, 16'd6);
        idle_i = 1'b0;
        // R2 run off
        wr(6'h01, 8'h00); t0_pulse();
        rd_cnt(c); chk("R2 run off", c, 16'd6);

        // R4 overflow with interrupt
        wr(6'h00, 8'h05); set_cnt(16'hFFFF); wr(6'h01, 8'h40); t0_pulse();
        rd_cnt(c); chk("R4 wrap", c, 16'h0000);
        rd(6'h01, r); chk("R4 flag", 16'(r), 16'hC0);
        chk("R11 ovf irq", 16'(irq_o), 16'h1);
        // R10 write 1 keeps, write 0 clears
        wr(6'h01, 8'hC0); rd(6'h01, r); chk("R10 keep", 16'(r), 16'hC0);
        wr(6'h01, 8'h40); rd(6'h01, r); chk("R10 clear", 16'(r), 16'h40);
        chk("R11 irq low", 16'(irq_o), 16'h0);
        // R10 set and clear in the same cycle
        set_cnt(16'hFFFF);
        @(negedge clk); wr_en = 1'b1; addr = 6'h01; wdata = 8'h40; t0_ovf_i = 1'b1;
        @(negedge clk); wr_en = 1'b0; t0_ovf_i = 1'b0;
        rd(6'h01, r); chk("R10 set wins", 16'(r), 16'hC0);
        wr(6'h01, 8'h40);

        // R6 / R9 software timer on channel 0
        wr(6'h08, 8'h49); wr(6'h10, 8'h00);
        rd(6'h08, r); chk("R9 lo clears", 16'(r), 16'h09);
        wr(6'h18, 8'h01);
        rd(6'h08, r); chk("R9 hi sets", 16'(r), 16'h49);
        set_cnt(16'h00FE); t0_pulse();
        rd(6'h01, r); chk("R6 no match", 16'(r), 16'h40);
        t0_pulse();
        rd(6'h01, r); chk("R6 match", 16'(r), 16'h41);
        chk("R11 ev irq", 16'(irq_o), 16'h1);
        wr(6'h08, 8'h48); chk("R11 ev masked", 16'(irq_o), 16'h0);
        wr(6'h01, 8'h40);

        // R7 toggle on channel 1
        wr(6'h09, 8'h4C); wr(6'h11, 8'h05); wr(6'h19, 8'h00);
        set_cnt(16'h0004); t0_pulse(); settle();
        chk("R7 toggle1", 16'(cex_o[1]), 16'h1);
        set_cnt(16'h0004); t0_pulse(); settle();
        chk("R7 toggle2", 16'(cex_o[1]), 16'h0);
        t0_pulse(); settle();
        chk("R7 hold", 16'(cex_o[1]), 16'h0);

        // R8 PWM threshold table on channel 2
        wr(6'h0A, 8'h42);
        foreach (PWM_VEC[k]) begin
            wr(6'h12, PWM_VEC[k][16:9]); wr(6'h1A, PWM_VEC[k][16:9]);
            set_cnt({8'h00, PWM_VEC[k][8:1]});
            chk("R8 pwm", 16'(cex_o[2]), 16'(PWM_VEC[k][0]));
        end
        // R8 reload of low byte from high byte at low-byte wrap
        wr(6'h12, 8'h40); wr(6'h1A, 8'h80); set_cnt(16'h00FF); t0_pulse();
        rd(6'h12, r); chk("R8 reload", 16'(r), 16'h80);
        set_cnt(16'h0090); chk("R8 new thr hi", 16'(cex_o[2]), 16'h1);
        set_cnt(16'h0070); chk("R8 new thr lo", 16'(cex_o[2]), 16'h0);

        // R5 capture, counter parked
        wr(6'h01, 8'h00); wr(6'h0A, 8'h00);
        wr(6'h0B, 8'h20); set_cnt(16'h1234);
        @(negedge clk); cex_i[3] = 1'b1; settle();
        rd(6'h01, r); chk("R5 rise flag", 16'(r), 16'h08);
        rd(6'h13, r); c[7:0] = r; rd(6'h1B, r); c[15:8] = r;
        chk("R5 rise cap", c, 16'h1234);
        wr(6'h01, 8'h00); set_cnt(16'h2222);
        @(negedge clk); cex_i[3] = 1'b0; settle();
        rd(6'h01, r); chk("R5 fall ignored flag", 16'(r), 16'h00);
        rd(6'h13, r); c[7:0] = r; rd(6'h1B, r); c[15:8] = r;
        chk("R5 fall ignored cap", c, 16'h1234);
        wr(6'h0C, 8'h30); set_cnt(16'h3333);
        @(negedge clk); cex_i[4] = 1'b1; settle();
        rd(6'h14, r); c[7:0] = r; rd(6'h1C, r); c[15:8] = r;
        chk("R5 both rise", c, 16'h3333);
        set_cnt(16'h4444);
        @(negedge clk); cex_i[4] = 1'b0; settle();
        rd(6'h14, r); c[7:0] = r; rd(6'h1C, r); c[15:8] = r;
        chk("R5 both fall", c, 16'h4444);
        rd(6'h01, r); chk("R5 both flag", 16'(r), 16'h10);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule